// File: doc/BRIEF.md
# Configurable I/O Event Detector

This block watches one already-synchronised input line and raises an event for an interrupt controller. A three-bit mode code picks the event kind: a falling edge, a rising edge, either edge, a low level or a high level. The three codes above those are unused and produce nothing. Edge events are latched in a sticky flag that stays set until software or the controller pulses the clear input. Level events are reported directly while the line sits at the chosen level.

An optional filter sits ahead of the detector and has two variants. The short-glitch filter runs on the main clock and accepts a new level only after two consecutive clock samples agree. The debounce filter runs on a divided slow-clock tick and accepts a new level only after two consecutive divided-tick samples agree. The divider counts incoming slow-tick strobes and fires on every `SLOW_DIV`-th one. With the filter switched off, the raw line goes straight to the detector.

All ports are plain levels and strobes. No data stream passes through the block, so there is no handshake. Reset is synchronous and active low. During reset the filter state and the previous-sample register load the live input, so that releasing reset cannot produce an edge.

Top module: `io_event_detect`

## Requirements
- R1: Mode code 0 (falling) sets the event flag one clock after the filtered level goes from 1 to 0. A rising transition does not set it.
- R2: Mode code 1 (rising) sets the event flag one clock after the filtered level goes from 0 to 1. A falling transition does not set it.
- R3: Mode code 2 (either) sets the event flag one clock after any change of the filtered level.
- R4: Mode code 3 (low) drives `evt_o` high, with no register delay, for as long as the filtered level is 0.
- R5: Mode code 4 (high) drives `evt_o` high, with no register delay, for as long as the filtered level is 1.
- R6: Mode codes 5, 6 and 7 hold `evt_o` at 0, and edges seen in these modes do not set the flag.
- R7: In an edge mode (codes 0 to 2) the flag stays set through later input changes. A one-clock `clr_i` pulse clears it at the next clock edge.
- R8: When a qualifying edge and `clr_i` arrive in the same clock, the flag ends up set.
- R9: With `filt_en_i` = 0, the raw `pin_i` reaches the detector without any register stage.
- R10: With `filt_en_i` = 1 and `filt_slow_i` = 0, the filtered level takes a new value only after `pin_i` shows that value at two consecutive clock edges. A one-clock pulse is removed.
- R11: With `filt_en_i` = 1 and `filt_slow_i` = 1, the filter samples only on every `SLOW_DIV`-th `slow_tick_i` pulse (default 4). A new level passes only after two consecutive such samples agree.
- R12: While `rst_n` = 0 the flag is cleared, and the filter state and previous sample load `pin_i`. After release, a steady input produces no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Synchronised line level |
| filt_en_i | input | 1 | 1 = filter in the path |
| filt_slow_i | input | 1 | 0 = clock glitch filter, 1 = slow-tick debounce |
| evt_mode_i | input | 3 | Event kind code (0 fall, 1 rise, 2 both, 3 low, 4 high, 5..7 unused) |
| slow_tick_i | input | 1 | Slow-clock strobe, one clock wide |
| clr_i | input | 1 | Clears the sticky edge flag |
| evt_o | output | 1 | Event flag (edge modes) or level match (level modes) |

## Verification
The bench drives a clear and an edge in the same clock. A design that gave the clear priority would lose that event. It sends single-clock pulses through the glitch filter and single-period pulses through the debounce filter; a filter that passed on one sample would let them through as events. The bench also issues slow ticks one short of a full divider period and checks that no sample is taken early. Finally, it releases reset with the line held high in rising mode. A design that loaded 0 into its previous-sample register would report a false edge there.

// File: rtl/iev_pkg.sv
package iev_pkg;
  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_mode_e;

  localparam int NUM_FILT = 2;  // 0: clock glitch filter, 1: slow debounce
endpackage

// File: rtl/iev_tick_div.sv
module iev_tick_div #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic tick_o
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  generate
    if (SLOW_DIV <= 1) begin : g_pass
      assign tick_o = tick_i;
    end else begin : g_cnt
      localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      assign tick_o = tick_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/iev_sampler.sv
module iev_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic smp_i,
  output logic lvl_o
);
  logic last_q, lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= pin_i;
      lvl_q  <= pin_i;
    end else if (smp_i) begin
      last_q <= pin_i;
      if (pin_i == last_q) lvl_q <= pin_i;  // two agreeing samples
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/iev_filter.sv
module iev_filter import iev_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  input  logic slow_i,
  input  logic dtick_i,
  output logic lvl_o
);
  logic [NUM_FILT-1:0] smp;
  logic [NUM_FILT-1:0] lvl;

  assign smp[0] = 1'b1;
  assign smp[1] = dtick_i;

  generate
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_smp
      iev_sampler u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i(pin_i),
        .smp_i(smp[g]),
        .lvl_o(lvl[g])
      );
    end
  endgenerate

  always_comb begin
    if (!en_i)       lvl_o = pin_i;
    else if (slow_i) lvl_o = lvl[1];
    else             lvl_o = lvl[0];
  end
endmodule

// File: rtl/iev_detect.sv
module iev_detect import iev_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic       evt_o,
  output logic       prv_o
);
  logic     prv_q, flag_q, rise, fall, hit;
  ev_mode_e mode;

  assign mode = ev_mode_e'(mode_i);
  assign rise = lvl_i & ~prv_q;
  assign fall = ~lvl_i & prv_q;

  always_comb begin
    case (mode)
      EV_FALL: hit = fall;
      EV_RISE: hit = rise;
      EV_BOTH: hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_q  <= pin_i;
      flag_q <= 1'b0;
    end else begin
      prv_q <= lvl_i;
      if (hit)        flag_q <= 1'b1;  // new edge beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (mode)
      EV_FALL, EV_RISE, EV_BOTH: evt_o = flag_q;
      EV_LOW:                    evt_o = ~lvl_i;
      EV_HIGH:                   evt_o = lvl_i;
      default:                   evt_o = 1'b0;
    endcase
  end

  assign prv_o = prv_q;
endmodule

// File: rtl/io_event_detect.sv
module io_event_detect #(
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       filt_en_i,
  input  logic       filt_slow_i,
  input  logic [2:0] evt_mode_i,
  input  logic       slow_tick_i,
  input  logic       clr_i,
  output logic       evt_o
);
  logic dtick, flt_lvl, prv_q;

  iev_tick_div #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(slow_tick_i),
    .tick_o(dtick)
  );

  iev_filter u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .en_i   (filt_en_i),
    .slow_i (filt_slow_i),
    .dtick_i(dtick),
    .lvl_o  (flt_lvl)
  );

  iev_detect u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .lvl_i (flt_lvl),
    .mode_i(evt_mode_i),
    .clr_i (clr_i),
    .evt_o (evt_o),
    .prv_o (prv_q)
  );
endmodule

// File: rtl/iev_checker.sv
module iev_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_i,
  input logic       filt_en_i,
  input logic       filt_slow_i,
  input logic [2:0] evt_mode_i,
  input logic       clr_i,
  input logic       evt_o,
  input logic       flt_lvl,
  input logic       prv_q
);
  logic past_ok, armed2, fast;

  assign fast = filt_en_i && !filt_slow_i;

  always_ff @(posedge clk) begin
    past_ok <= rst_n;
    armed2  <= rst_n && past_ok;
  end

  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mode_i > 3'd4) |-> !evt_o);

  a_r4_low_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en_i && evt_mode_i == 3'd3) |-> (evt_o == !pin_i));

  // R5 and R9: unfiltered high-level mode mirrors the pin
  a_r9_high_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en_i && evt_mode_i == 3'd4) |-> (evt_o == pin_i));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && evt_mode_i < 3'd3 && $past(evt_mode_i) < 3'd3
     && $past(evt_o) && !$past(clr_i)) |-> evt_o);

  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && evt_mode_i == 3'd2 && $past(evt_mode_i) == 3'd2
     && $past(flt_lvl != prv_q)) |-> evt_o);

  a_r10_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (armed2 && fast && $past(fast) && $past(fast, 2)
     && flt_lvl != $past(flt_lvl))
    |-> (flt_lvl == $past(pin_i) && flt_lvl == $past(pin_i, 2)));

  a_r12_no_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!past_ok && evt_mode_i < 3'd3) |-> !evt_o);
endmodule

bind io_event_detect iev_checker u_iev_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_i      (pin_i),
  .filt_en_i  (filt_en_i),
  .filt_slow_i(filt_slow_i),
  .evt_mode_i (evt_mode_i),
  .clr_i      (clr_i),
  .evt_o      (evt_o),
  .flt_lvl    (flt_lvl),
  .prv_q      (prv_q)
);

// File: tb/test_io_event_detect.sv
`timescale 1ns/1ps
module test_io_event_detect;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       fen = 1'b0;
  logic       fslow = 1'b0;
  logic [2:0] mode = 3'd1;
  logic       tick = 1'b0;
  logic       clr = 1'b0;
  logic       evt;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  always #5 clk = ~clk;

  io_event_detect #(.SLOW_DIV(DIV)) i_io_event_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .filt_en_i(fen),
    .filt_slow_i(fslow), .evt_mode_i(mode), .slow_tick_i(tick),
    .clr_i(clr), .evt_o(evt)
  );

  // monitor: pops expectations and compares against the live output
  always begin
    wait (sbq.size() != 0);
    begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (evt !== it.exp) begin
        n_bad++;
        $display("FAIL %s: evt_o=%0b expected %0b", it.tag, evt, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_evt(input bit e, input string tag);
    sbq.push_back('{exp: e, tag: tag});
    wait (sbq.size() == 0);
    #0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic slow_period();
    for (int k = 0; k < DIV; k++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_evt(1'b0, "R12 rise mode after reset, pin held high");
    mode = 3'd0; step();
    expect_evt(1'b0, "R12 fall mode, steady pin");

    // R1 falling
    pin = 1'b0; step();
    expect_evt(1'b1, "R1 falling edge sets flag");
    pulse_clr();
    expect_evt(1'b0, "R7 clear drops flag");
    pin = 1'b1; step();
    expect_evt(1'b0, "R1 rising edge ignored");

    // R7 sticky
    pin = 1'b0; step();
    expect_evt(1'b1, "R7 flag set");
    pin = 1'b1; step();
    expect_evt(1'b1, "R7 flag held after pin returns");
    step();
    expect_evt(1'b1, "R7 flag still held");
    pulse_clr();
    expect_evt(1'b0, "R7 cleared");

    // R2 rising
    mode = 3'd1;
    pin = 1'b0; step();
    expect_evt(1'b0, "R2 falling edge ignored");
    pin = 1'b1; step();
    expect_evt(1'b1, "R2 rising edge sets flag");
    pulse_clr();

    // R3 both
    mode = 3'd2;
    pin = 1'b0; step();
    expect_evt(1'b1, "R3 falling edge");
    pulse_clr();
    expect_evt(1'b0, "R3 cleared");
    pin = 1'b1; step();
    expect_evt(1'b1, "R3 rising edge");
    pulse_clr();

    // R8 edge with clear on same cycle
    pin = 1'b0; clr = 1'b1; step(); clr = 1'b0;
    expect_evt(1'b1, "R8 edge beats clear");
    pulse_clr();
    expect_evt(1'b0, "R8 later clear works");

    // R4 / R9 low level, unfiltered, no register stage
    mode = 3'd3; #1;
    expect_evt(1'b1, "R4 low level with pin=0");
    pin = 1'b1; #1;
    expect_evt(1'b0, "R9 pin change seen at once");

    // R5 high level
    mode = 3'd4; #1;
    expect_evt(1'b1, "R5 high level with pin=1");
    pin = 1'b0; #1;
    expect_evt(1'b0, "R5 pin low");
    step();

    // R6 reserved codes
    for (int c = 5; c < 8; c++) begin
      mode = 3'(c);
      pin = 1'b1; step();
      expect_evt(1'b0, "R6 reserved, pin high");
      pin = 1'b0; step();
      expect_evt(1'b0, "R6 reserved, pin low");
    end
    mode = 3'd2; step();
    expect_evt(1'b0, "R6 no flag left from reserved mode");

    // R10 glitch filter
    mode = 3'd4; fen = 1'b1; fslow = 1'b0;
    repeat (3) step();
    expect_evt(1'b0, "R10 settled low");
    pin = 1'b1; step(); pin = 1'b0;
    expect_evt(1'b0, "R10 after one sample");
    step(); step();
    expect_evt(1'b0, "R10 one-clock pulse removed");
    pin = 1'b1; step();
    expect_evt(1'b0, "R10 one agreeing sample only");
    step();
    expect_evt(1'b1, "R10 second sample passes level");
    pin = 1'b0; step();
    expect_evt(1'b1, "R10 fall delayed");
    step();
    expect_evt(1'b0, "R10 fall passes");

    // R11 debounce: sampler loaded 1 at reset, divider at 0
    fslow = 1'b1; #1;
    expect_evt(1'b1, "R11 stale debounced level");
    for (int k = 0; k < DIV - 1; k++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
    expect_evt(1'b1, "R11 no sample before divider period");
    tick = 1'b1; step(); tick = 1'b0; step();
    expect_evt(1'b1, "R11 one disagreeing sample");
    slow_period();
    expect_evt(1'b0, "R11 two samples pass low");
    pin = 1'b1; slow_period(); pin = 1'b0;
    expect_evt(1'b0, "R11 single-period pulse held off");
    slow_period();
    expect_evt(1'b0, "R11 pulse removed");
    slow_period();
    expect_evt(1'b0, "R11 still low");
    pin = 1'b1; slow_period();
    expect_evt(1'b0, "R11 one high sample");
    slow_period();
    expect_evt(1'b1, "R11 two high samples pass");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule